// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is a configurable AND-OR logic plane. Twenty-two input signals (twelve dedicated inputs and ten feedback lines) each give a true and a complement literal. Every product-term row of the plane is defined by one configuration bit per literal. A row ANDs the literals it is connected to. Groups of rows are ORed into ten sum outputs of unequal size. The same plane also supplies one output-enable term for each output, plus one shared reset term and one shared set term. These feed the output stage that sits next to the block.

The configuration image is loaded serially, one bit per clock, while the load input is high. Until a complete image has been loaded, and for as long as loading goes on, every output of the block is held at 0. The plane itself is combinational. Once the image is in place, an input change reaches the outputs in the same cycle.

Top module: `pal_sop_array`

## Requirements
- R1: Literal column 2*i carries input i and column 2*i+1 carries its complement. Inputs 0 to 11 are `ded_i[0..11]` and inputs 12 to 21 are `fb_i[0..9]`, which gives 44 columns.
- R2: A configuration bit of 0 (intact) connects its literal to the row, and a bit of 1 (open) disconnects it. A row's value is the AND of its connected literals. A row with all bits intact is 0, and a row with all bits open is 1.
- R3: Configuration bit number = row * 44 + column. There are 132 rows, using bits 0 to 5807.
- R4: Row 0 is the shared reset term (`ar_o`). For each output k = 0..9 in turn there is first its enable row (`oe_o[k]`) and then its sum rows. Row 131 is the shared set term (`ss_o`).
- R5: `sum_o[k]` is the OR of its sum rows. Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 rows respectively.
- R6: Each clock with `cfg_load` high shifts `cfg_bit` into the image, with bit 0 sent first. The first high cycle after a low one starts a new load from bit 0.
- R7: All outputs are 0 while `cfg_load` is high and after reset. They are also 0 whenever fewer than 5808 bits have been shifted since the last load started.
- R8: Bits offered after the 5808th bit of one load are ignored.
- R9: The image does not change while `cfg_load` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Serial load enable |
| cfg_bit | input | 1 | Serial configuration bit |
| ded_i | input | 12 | Dedicated inputs |
| fb_i | input | 10 | Feedback inputs |
| sum_o | output | 10 | Sum outputs |
| oe_o | output | 10 | Per-output enable terms |
| ar_o | output | 1 | Shared reset term |
| ss_o | output | 1 | Shared set term |

## Verification
The assertions assume that `cfg_load` and `cfg_bit` change only away from the rising clock edge. They also assume that a load is never expected to finish while `cfg_load` is still high. The bench drives every input on the falling edge. It lowers `cfg_load` only after a complete image, after a deliberately short one, or after a short run of extra bits. The data inputs change only while the load enable is low, so each vector settles on a fixed image.

// File: rtl/pal_pkg.sv
package pal_pkg;
   localparam int unsigned PAL_N_DED = 12;
   localparam int unsigned PAL_N_FB  = 10;

   typedef enum logic {
      POL_TRUE = 1'b0,
      POL_COMP = 1'b1
   } lit_pol_e;
endpackage

// File: rtl/pal_cfg_loader.sv
module pal_cfg_loader #(
   parameter int unsigned N_BITS = 5808,
   parameter int unsigned CW     = $clog2(N_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              load_bit,
   output logic [N_BITS-1:0] image,
   output logic [CW-1:0]     count,
   output logic              ready
);
   localparam logic [CW-1:0] FULL = CW'(N_BITS);

   logic load_q;
   logic start;
   logic shift;

   assign start = load_en && !load_q;
   assign shift = start || (load_en && (count != FULL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= 1'b0;
         count  <= '0;
      end else begin
         load_q <= load_en;
         if (start)
            count <= CW'(1);
         else if (shift)
            count <= count + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         image <= '0;
      else if (shift)
         image <= {load_bit, image[N_BITS-1:1]};
   end

   assign ready = !load_en && (count == FULL);
endmodule

// File: rtl/pal_literal_gen.sv
module pal_literal_gen
   import pal_pkg::*;
#(
   parameter int unsigned N_DED = PAL_N_DED,
   parameter int unsigned N_FB  = PAL_N_FB,
   parameter int unsigned N_IN  = N_DED + N_FB,
   parameter int unsigned N_COL = 2 * N_IN
) (
   input  logic [N_DED-1:0] ded,
   input  logic [N_FB-1:0]  fb,
   output logic [N_COL-1:0] lit
);
   logic [N_IN-1:0] src;
   assign src = {fb, ded};

   for (genvar i = 0; i < N_IN; i++) begin : g_col
      assign lit[2*i + int'(POL_TRUE)] = src[i];
      assign lit[2*i + int'(POL_COMP)] = ~src[i];
   end
endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
   parameter int unsigned N_COL = 44
) (
   input  logic [N_COL-1:0] lit,
   input  logic [N_COL-1:0] row_cfg,
   output logic             term
);
   assign term = &(lit | row_cfg);
endmodule

// File: rtl/pal_sop_array.sv
module pal_sop_array
   import pal_pkg::*;
#(
   parameter int unsigned N_DED = PAL_N_DED,
   parameter int unsigned N_FB  = PAL_N_FB,
   parameter int unsigned N_OUT = 10,
   parameter int unsigned SUM_TERMS [N_OUT] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic             cfg_bit,
   input  logic [N_DED-1:0] ded_i,
   input  logic [N_FB-1:0]  fb_i,
   output logic [N_OUT-1:0] sum_o,
   output logic [N_OUT-1:0] oe_o,
   output logic             ar_o,
   output logic             ss_o
);
   function automatic int unsigned out_base(int unsigned k);
      int unsigned acc = 1;
      for (int unsigned j = 0; j < k; j++)
         acc += 1 + SUM_TERMS[j];
      return acc;
   endfunction

   localparam int unsigned N_IN   = N_DED + N_FB;
   localparam int unsigned N_COL  = 2 * N_IN;
   localparam int unsigned N_ROWS = out_base(N_OUT) + 1;
   localparam int unsigned N_BITS = N_ROWS * N_COL;
   localparam int unsigned CW     = $clog2(N_BITS + 1);
   localparam int unsigned AR_ROW = 0;
   localparam int unsigned SS_ROW = N_ROWS - 1;

   if (N_FB != N_OUT) begin : g_bad_fb
      $error("feedback count must equal output count");
   end
   if (N_DED == 0) begin : g_bad_ded
      $error("at least one dedicated input is required");
   end

   logic [N_BITS-1:0] cfg_img;
   logic [CW-1:0]     load_cnt;
   logic              img_ready;
   logic [N_COL-1:0]  lit;
   logic [N_ROWS-1:0] pt;
   logic [N_OUT-1:0]  sum_raw;
   logic [N_OUT-1:0]  oe_raw;

   pal_cfg_loader #(.N_BITS(N_BITS), .CW(CW)) u_loader (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (cfg_load),
      .load_bit (cfg_bit),
      .image    (cfg_img),
      .count    (load_cnt),
      .ready    (img_ready)
   );

   pal_literal_gen #(.N_DED(N_DED), .N_FB(N_FB)) u_lit (
      .ded (ded_i),
      .fb  (fb_i),
      .lit (lit)
   );

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      pal_pterm #(.N_COL(N_COL)) u_pt (
         .lit     (lit),
         .row_cfg (cfg_img[r*N_COL +: N_COL]),
         .term    (pt[r])
      );
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      localparam int unsigned BASE = out_base(k);
      localparam int unsigned NT   = SUM_TERMS[k];
      if (NT == 0) begin : g_empty
         assign sum_raw[k] = 1'b0;
      end else begin : g_or
         assign sum_raw[k] = |pt[BASE+1 +: NT];
      end
      assign oe_raw[k] = pt[BASE];
   end

   assign sum_o = img_ready ? sum_raw : '0;
   assign oe_o  = img_ready ? oe_raw  : '0;
   assign ar_o  = img_ready & pt[AR_ROW];
   assign ss_o  = img_ready & pt[SS_ROW];
endmodule

// File: rtl/pal_sop_chk.sv
module pal_sop_chk #(
   parameter int unsigned N_OUT  = 10,
   parameter int unsigned N_BITS = 5808,
   parameter int unsigned CW     = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_en,
   input logic [N_OUT-1:0]  sum,
   input logic [N_OUT-1:0]  oe,
   input logic              ar,
   input logic              ss,
   input logic [CW-1:0]     count,
   input logic [N_BITS-1:0] image
);
   localparam logic [CW-1:0] FULL = CW'(N_BITS);

   // R7
   a_r7_quiet_loading: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> (sum == '0 && oe == '0 && !ar && !ss));

   // R7
   a_r7_quiet_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (count != FULL) |-> (sum == '0 && oe == '0 && !ar && !ss));

   // R6
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_en) |=> (count == CW'(1)));

   // R8
   a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL);

   // R9
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> $stable(image));
endmodule

bind pal_sop_array pal_sop_chk #(.N_OUT(N_OUT), .N_BITS(N_BITS), .CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load_en (cfg_load),
   .sum     (sum_o),
   .oe      (oe_o),
   .ar      (ar_o),
   .ss      (ss_o),
   .count   (load_cnt),
   .image   (cfg_img)
);

// File: tb/tb_pal_sop_array.sv
module tb_pal_sop_array;
   localparam int CLK_PERIOD = 10;
   localparam int NCOL  = 44;
   localparam int NBITS = 5808;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_load = 1'b0;
   logic       cfg_bit = 1'b0;
   logic [11:0] ded_i = '0;
   logic [9:0]  fb_i = '0;
   logic [9:0]  sum_o, oe_o;
   logic        ar_o, ss_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pal_sop_array dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
      .ded_i(ded_i), .fb_i(fb_i), .sum_o(sum_o), .oe_o(oe_o),
      .ar_o(ar_o), .ss_o(ss_o)
   );

   // fields: ded[43:32] fb[31:22] sum[21:12] oe[11:2] ar[1] ss[0]
   localparam logic [43:0] VEC [0:6] = '{
      {12'h000, 10'h000, 10'h000, 10'h000, 1'b1, 1'b1},
      {12'h002, 10'h000, 10'h001, 10'h000, 1'b1, 1'b1},
      {12'h006, 10'h000, 10'h000, 10'h000, 1'b1, 1'b1},
      {12'h809, 10'h000, 10'h010, 10'h001, 1'b1, 1'b0},
      {12'h800, 10'h201, 10'h200, 10'h000, 1'b1, 1'b1},
      {12'hFFF, 10'h3FF, 10'h200, 10'h001, 1'b1, 1'b0},
      {12'h803, 10'h200, 10'h211, 10'h001, 1'b1, 1'b1}
   };

   // Image A: 1 = open. Rows listed are open except the named intact columns.
   // R4 row map: 0 reset, 1 enable of out0, 2 first sum row of out0,
   // 65 last sum row of out4, 130 last sum row of out9, 131 set.
   function automatic logic img_a(int b);
      int row = b / NCOL;
      int col = b % NCOL;
      case (row)
         0:   return 1'b1;
         1:   return col != 0;
         2:   return !(col == 2 || col == 5);
         65:  return !(col == 22 || col == 25);
         130: return col != 42;
         131: return col != 7;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] outs();
      return {10'b0, sum_o, oe_o, ar_o, ss_o};
   endfunction

   // which: 0 = image A, 1 = all open. nbits shifted, then extra zeros.
   task automatic load(int which, int nbits, int extra);
      @(negedge clk);
      cfg_load = 1'b1;
      for (int b = 0; b < nbits + extra; b++) begin
         cfg_bit = (b >= nbits) ? 1'b0 : ((which == 0) ? img_a(b) : 1'b1);
         @(negedge clk);
         if (b == 10) begin
            #1;
            check("R7 loading", outs(), 32'h0);
         end
      end
      cfg_load = 1'b0;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R7 reset", outs(), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R7 unloaded", outs(), 32'h0);

      load(0, NBITS, 0);
      // R1 R2 R3 R4 R5: vector walk on image A
      for (int v = 0; v < 7; v++) begin
         ded_i = VEC[v][43:32];
         fb_i  = VEC[v][31:22];
         #1;
         check($sformatf("R1 R2 R3 R4 R5 vec%0d", v), outs(), {10'b0, VEC[v][21:0]});
         @(negedge clk);
      end
      #1;
      check("R9 image held", outs(), {10'b0, VEC[6][21:0]});

      // R6 R7: short load restarts and leaves the array unloaded
      load(1, 100, 0);
      check("R7 partial", outs(), 32'h0);

      // R8: all-open image with extra zero bits appended
      load(1, NBITS, 8);
      check("R8 extra ignored", outs(), {10'b0, 10'h3FF, 10'h3FF, 1'b1, 1'b1});
      ded_i = 12'h555;
      fb_i  = 10'h0AA;
      #1;
      check("R2 all open", outs(), {10'b0, 10'h3FF, 10'h3FF, 1'b1, 1'b1});

      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R7 reset again", outs(), 32'h0);
      rst_n = 1'b1;

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule